// File: doc/BRIEF.md
# Trip Flag and Interrupt Controller

This block keeps the latched trip status of one PWM channel. Six single-cycle trip event inputs (cycle-by-cycle, one-shot, and two compare events each on side A and side B) set sticky flags. Software reads the flags through a status register and removes them by writing ones to a clear register on a simple memory-mapped bus. Writing 0 to a bit of that register does nothing.

A per-source enable register chooses which flags may raise a global interrupt flag. When the global flag goes from 0 to 1, the block emits a one-clock interrupt pulse. While the global flag stays set, no further pulses are produced. When software clears the global flag and an enabled trip flag is still set, the global flag sets again and a fresh pulse follows. If software clears every flag in one write, the block stays quiet until a new trip event arrives.

Top module: `trip_flag_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all trip flags, the global flag, all enables and the interrupt output. All registers read 0 after reset.
- R2: A high level on `trip_evt[i]` at a clock edge sets flag bit i+1 of the flag register (byte offset 0x28). The bit layout is: 1 cycle-by-cycle, 2 one-shot, 3 A event 1, 4 A event 2, 5 B event 1, 6 B event 2. A set flag stays set until it is cleared.
- R3: A write to the clear register (offset 0x2C) clears each flag whose bit is 1 in the written data, using the same layout with bit 0 as the global flag. Any flag whose bit is 0 in the written data keeps its value.
- R4: If a trip event and a clear of the same flag occur at the same edge, the flag is set after that edge.
- R5: The clear register always reads 0. Bits 15 to 7 of the flag and enable registers read 0, and bit 0 of the enable register reads 0.
- R6: The enable register (offset 0x24) holds bits 1 to 6. When a flag with its enable bit set is present, the global flag (flag register bit 0) sets at the next edge. Flags without their enable bit never set the global flag.
- R7: `irq_pulse` is high for exactly one clock, in the cycle in which the global flag first reads 1.
- R8: While the global flag stays set, further trip events produce no pulse.
- R9: If only the global flag is cleared while an enabled flag remains set, the global flag reads 0 for one cycle, then sets again with a new pulse.
- R10: Clearing all seven bits in one write leaves the global flag at 0 and produces no pulse until a new enabled trip event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| trip_evt | input | 6 | Single-cycle trip events (bit 0 cycle-by-cycle to bit 5 B event 2) |
| irq_pulse | output | 1 | One-clock trip interrupt pulse |

## Verification
The assertions check the cycle-level rules on every cycle. An event always leaves its flag set, and a clear with no competing event always removes the flag. The pulse lasts one clock and occurs only on a rise of the global flag, and that rise always follows an enabled pending flag. A held global flag suppresses pulses, and a dropped global flag with enabled flags still set pulses on the next cycle. The bench scenarios cover what depends on register decoding and on software sequences. They sweep every source with its enable on and off and compare the flag register with the expected value. They also check the read-as-zero fields, and they count pulses across clearing only the global flag and clearing everything at once.

// File: rtl/tz_pkg.sv
package tz_pkg;
  localparam int NSRC   = 6;
  localparam int FLAG_W = NSRC + 1;
  typedef logic [FLAG_W-1:0] tzvec_t;
  localparam tzvec_t SRC_MASK = tzvec_t'({NSRC{1'b1}}) << 1;

  // Next value of a sticky flag set: a set wins over a clear
  function automatic tzvec_t sticky_next(tzvec_t cur, tzvec_t setv, tzvec_t clrv);
    return (cur & ~clrv) | setv;
  endfunction

  // Place event inputs into flag positions 1..NSRC
  function automatic tzvec_t evt_to_vec(logic [NSRC-1:0] evt);
    return {evt, 1'b0};
  endfunction
endpackage

// File: rtl/tz_regif.sv
module tz_regif
  import tz_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter logic [ADDR_W-1:0] OFS_EN  = 'h24,
  parameter logic [ADDR_W-1:0] OFS_FLG = 'h28,
  parameter logic [ADDR_W-1:0] OFS_CLR = 'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  tzvec_t            flag_view,
  output tzvec_t            clr_strobe,
  output tzvec_t            int_en
);
  localparam int PAD_W = DATA_W - FLAG_W;

  logic wr_en_reg, wr_clr_reg;
  assign wr_en_reg  = bus_wr && (bus_addr == OFS_EN);
  assign wr_clr_reg = bus_wr && (bus_addr == OFS_CLR);

  assign clr_strobe = wr_clr_reg ? tzvec_t'(bus_wdata[FLAG_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst)            int_en <= '0;
    else if (wr_en_reg) int_en <= tzvec_t'(bus_wdata[FLAG_W-1:0]) & SRC_MASK;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_FLG)     bus_rdata = {{PAD_W{1'b0}}, flag_view};
    else if (bus_addr == OFS_EN) bus_rdata = {{PAD_W{1'b0}}, int_en};
  end

  // R6
  en_bit0_zero_chk: assert property (@(posedge clk) disable iff (rst) int_en[0] == 1'b0);
endmodule

// File: rtl/tz_flag_bank.sv
module tz_flag_bank
  import tz_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] trip_evt,
  input  tzvec_t          clr_strobe,
  output tzvec_t          src_flags
);
  tzvec_t set_vec, clr_vec, nxt;
  assign set_vec = evt_to_vec(trip_evt);
  assign clr_vec = clr_strobe & SRC_MASK;
  assign nxt     = sticky_next(src_flags, set_vec, clr_vec);

  always_ff @(posedge clk) begin
    if (rst) src_flags <= '0;
    else     src_flags <= nxt;
  end

  // R2 / R4
  set_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|trip_evt) |=> ((src_flags & $past(set_vec)) == $past(set_vec)));
  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~set_vec)) |=> ((src_flags & $past(clr_vec & ~set_vec)) == '0));
  // R2
  bit0_unused_chk: assert property (@(posedge clk) disable iff (rst) src_flags[0] == 1'b0);
endmodule

// File: rtl/tz_int_latch.sv
module tz_int_latch
  import tz_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  tzvec_t src_flags,
  input  tzvec_t int_en,
  input  logic   clr_global,
  output logic   gflag,
  output logic   irq_pulse
);
  logic set_req, g_nxt;
  assign set_req = |(src_flags & int_en);
  assign g_nxt   = clr_global ? 1'b0 : (gflag | set_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      gflag     <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      gflag     <= g_nxt;
      irq_pulse <= g_nxt & ~gflag;
    end
  end

  // R7
  pulse_one_chk: assert property (@(posedge clk) disable iff (rst) irq_pulse |=> !irq_pulse);
  // R7
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (gflag && !$past(gflag)));
  // R6
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gflag) |-> $past(set_req));
  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (gflag && !clr_global) |=> (gflag && !irq_pulse));
  // R9
  repulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!gflag && set_req && !clr_global) |=> irq_pulse);
endmodule

// File: rtl/trip_flag_ctrl.sv
module trip_flag_ctrl
  import tz_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   trip_evt,
  output logic              irq_pulse
);
  tzvec_t clr_strobe, int_en, src_flags, flag_view;
  logic   gflag;

  assign flag_view = src_flags | tzvec_t'(gflag);

  tz_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_view(flag_view),
    .clr_strobe(clr_strobe), .int_en(int_en));

  tz_flag_bank u_flags (
    .clk(clk), .rst(rst), .trip_evt(trip_evt),
    .clr_strobe(clr_strobe), .src_flags(src_flags));

  tz_int_latch u_latch (
    .clk(clk), .rst(rst), .src_flags(src_flags), .int_en(int_en),
    .clr_global(clr_strobe[0]), .gflag(gflag), .irq_pulse(irq_pulse));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq_pulse && flag_view == '0));
endmodule

// File: tb/trip_flag_ctrl_tb.sv
module trip_flag_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [5:0]  trip_evt = 0;
  logic        irq_pulse;

  int total = 0, bad = 0, irq_cnt = 0;

  localparam logic [7:0] A_EN = 8'h24, A_FLG = 8'h28, A_CLR = 8'h2C;

  trip_flag_ctrl u_dut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trip_evt(trip_evt), .irq_pulse(irq_pulse));

  always #4 clk = ~clk;

  always @(negedge clk) if (!rst && irq_pulse) irq_cnt++;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic fire(logic [5:0] e);
    trip_evt = e;
    @(negedge clk);
    trip_evt = 0;
  endtask

  initial begin
    step(200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, c0;
    step(3);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    rd(A_FLG, v); check("R1 flags", v, 0);
    rd(A_EN, v);  check("R1 enables", v, 0);
    check("R1 irq", irq_pulse, 0);

    // R5: read-as-zero fields
    wr(A_EN, 16'hFFFF);
    rd(A_EN, v);  check("R5 enable mask", v, 16'h007E);
    rd(A_CLR, v); check("R5 clear reads 0", v, 0);
    wr(A_EN, 16'h0000);

    // R2/R6/R7: sweep each source with enable off then on
    for (int s = 0; s < 6; s++) begin
      for (int en = 0; en < 2; en++) begin
        wr(A_EN, en ? (16'h1 << (s + 1)) : 16'h0);
        c0 = irq_cnt;
        fire(6'h1 << s);
        check("R7 no pulse before global", irq_pulse, 0);
        step(1);
        check("R7 pulse timing", irq_pulse, en);
        step(1);
        check("R7 pulse width", irq_pulse, 0);
        step(2);
        rd(A_FLG, v);
        check("R2 R6 flag reg", v, (1 << (s + 1)) | en);
        check("R6 pulse count", irq_cnt - c0, en);
        wr(A_CLR, 16'h007F);
        step(1);
        rd(A_FLG, v); check("R3 cleared", v, 0);
      end
    end

    // R3: writing zeros has no effect, single-bit clear
    wr(A_EN, 16'h0000);
    fire(6'h3F);
    wr(A_CLR, 16'h0000);
    rd(A_FLG, v); check("R3 zero write", v, 16'h007E);
    wr(A_CLR, 16'h0008);
    rd(A_FLG, v); check("R3 bit3 clear", v, 16'h0076);

    // R4: set and clear of same flag together
    bus_wr = 1; bus_addr = A_CLR; bus_wdata = 16'h0008; trip_evt = 6'h04;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0; trip_evt = 0;
    rd(A_FLG, v); check("R4 set wins", v, 16'h007E);
    wr(A_CLR, 16'h007F);

    // R8/R9/R10
    wr(A_EN, 16'h007E);
    c0 = irq_cnt;
    fire(6'h01);
    step(3);
    check("R7 first pulse", irq_cnt - c0, 1);
    fire(6'h02);
    step(3);
    check("R8 held global no pulse", irq_cnt - c0, 1);
    wr(A_CLR, 16'h0001);
    rd(A_FLG, v); check("R9 global dropped", v, 16'h0006);
    step(1);
    check("R9 repulse", irq_pulse, 1);
    rd(A_FLG, v); check("R9 global back", v, 16'h0007);
    step(2);
    check("R9 count", irq_cnt - c0, 2);
    wr(A_CLR, 16'h007F);
    step(5);
    rd(A_FLG, v); check("R10 all clear", v, 0);
    check("R10 no pulse", irq_cnt - c0, 2);
    fire(6'h20);
    step(3);
    check("R10 new event pulses", irq_cnt - c0, 3);

    // R1: reset again mid-state
    rst = 1; step(1); rst = 0;
    rd(A_FLG, v); check("R1 flags after reset", v, 0);
    rd(A_EN, v);  check("R1 en after reset", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule